// File: doc/BRIEF.md
# Capture/Reload Timer with Prescaler

A 16-bit timer/counter for general event timing. Four 16-bit registers sit on a simple register bus with a write strobe and a combinational read: a control/status word, the live count, a shared reload/capture register and a compare register. The count advances on ticks from a prescaler that divides the clock by 1, 4, 16, 64, 256 or 1024.

In reload mode the counter runs through a fixed period set by the reload register. Counting up, it wraps to zero after it reaches the reload value. Counting down, it reloads that value after it reaches zero. In capture mode it runs through the full 16-bit range, and a falling edge on the external pin saves the count. The external pin is synchronized inside the block. Depending on the mode it causes captures or forced reloads, and with direction control set its level chooses the count direction. A compare output and an interrupt line complete the block.

Register map (addr_i): 0 = control/status, 1 = count, 2 = reload/capture, 3 = compare. Control/status bits: [0] run, [1] capture mode (0 = reload mode), [2] external pin enable, [3] direction control, [4] output enable, [5] interrupt enable, [8:6] prescaler code, [13:9] read as 0, [14] external flag, [15] overflow flag.

Top module: `tmr_cap_reload`

## Requirements
- R1: After reset every register reads 0, and tmr_o and irq_o are 0.
- R2: The count changes only on a prescaler tick while run (bit 0) is 1. With run at 0 the count and the prescaler phase hold. Writing run=1 starts the prescaler from phase 0.
- R3: Prescaler code (bits 8:6) values 0 to 5 give a tick every 1, 4, 16, 64, 256 and 1024 clocks. Codes 6 and 7 give a tick every clock. After run is set, k clocks give floor(k/divisor) ticks.
- R4: Reload mode counting up: a tick with count equal to the reload value loads 0, sets the overflow flag (bit 15) and toggles the external flag (bit 14). Any other tick adds 1.
- R5: Direction control (bit 3) at 0 counts up. At 1, a synchronized pin level of 1 counts up and a level of 0 counts down. Reload mode counting down: a tick at count 0 loads the reload value and sets overflow (with the same toggle). Any other tick subtracts 1.
- R6: Capture mode: the count wraps 0xFFFF to 0 going up and 0 to 0xFFFF going down, sets overflow and leaves the external flag unchanged. With the pin enable (bit 2) at 1, a falling pin edge copies the count into register 2 and sets the external flag.
- R7: Reload mode with the pin enable at 1: a falling pin edge forces the count to 0 when counting up and to the reload value when counting down. It takes priority over a tick in the same clock and sets the external flag only when counting up. The edge acts whether run is set or not, 3 clocks after the pin falls (2-flop synchronizer plus edge register).
- R8: With the pin enable at 0, pin edges change neither the count, register 2 nor the external flag.
- R9: The overflow and external flags stay set until software writes 0 to them through register 0. Writing 1 leaves them set.
- R10: irq_o = interrupt enable (bit 5) AND (overflow flag OR a pending pin event). A pin event is recorded by any edge that sets the external flag and is cleared by writing bit 14 to 0. An external flag set only by the wrap toggle does not raise irq_o.
- R11: tmr_o is 1 when output enable (bit 4) is 1 and the count is below the compare register, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register (combinational) |
| ext_pin_i | input | 1 | External capture/reload/direction pin (asynchronous) |
| tmr_o | output | 1 | Compare output |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong count or a wrong wrap choice appears in the count register on the very next tick and stays there. The bench compares counts after a known number of clocks against closed-form period arithmetic, for both directions and several prescaler codes. A bad flag update shows on bit 14 or 15 and on irq_o in the clock after the wrap or edge. Errors in the synchronizer or edge path show up 3 clocks after a pin fall as a missing or wrong capture or forced reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 10;
  localparam int CODE_W = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_RLD  = 2'd2;
  localparam logic [1:0] A_CMP  = 2'd3;

  typedef struct packed {
    logic [CODE_W-1:0] presc;
    logic irq_en;
    logic out_en;
    logic dir_ctl;
    logic ext_en;
    logic cap;
    logic run;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // divisor - 1 for a prescaler code: 4**code for codes 0..5, else 1
  function automatic logic [PS_W-1:0] presc_lim(input logic [CODE_W-1:0] code);
    logic [PS_W:0] one_hot;
    if (code > 3'd5) return '0;
    one_hot = (PS_W+1)'(1) << (2 * int'(code));
    return PS_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= level_o;
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;

  // R7: one edge pulse per falling transition
  assert_fall_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] lim;
  logic            slow;

  assign lim    = presc_lim(code_i);
  assign slow   = (code_i >= 3'd1) && (code_i <= 3'd5);
  assign tick_o = run_i && (ps_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ps_q <= '0;
    else if (!run_i || tick_o)  ps_q <= '0;
    else                        ps_q <= ps_q + 1'b1;
  end

  // R3: divided codes never tick on two consecutive clocks
  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && slow) |=> (!tick_o || !slow));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cfg_t         cfg_i,
  input  logic         tick_i,
  input  logic         level_i,
  input  logic         fall_i,
  input  logic         wr_ctrl_i,
  input  logic         wr_cnt_i,
  input  logic         wr_rld_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_o,
  output logic         extf_o,
  output logic         evt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic         ovf_q, ovf_d, extf_q, extf_d, evt_q, evt_d;
  logic         up, hit, edge_rl, edge_cp;

  assign up      = !cfg_i.dir_ctl || level_i;
  assign hit     = up ? (cfg_i.cap ? (cnt_q == CNT_MAX) : (cnt_q == rld_q)) : (cnt_q == '0);
  assign edge_rl = cfg_i.ext_en && fall_i && !cfg_i.cap;
  assign edge_cp = cfg_i.ext_en && fall_i &&  cfg_i.cap;

  always_comb begin
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    ovf_d  = wr_ctrl_i ? wdata_i[W-1] : ovf_q;
    extf_d = wr_ctrl_i ? wdata_i[W-2] : extf_q;
    evt_d  = (wr_ctrl_i && !wdata_i[W-2]) ? 1'b0 : evt_q;
    if (edge_rl) begin
      cnt_d = up ? '0 : rld_q;
      if (up) begin
        extf_d = 1'b1;
        evt_d  = 1'b1;
      end
    end else if (tick_i) begin
      if (hit) begin
        cnt_d = up ? '0 : (cfg_i.cap ? CNT_MAX : rld_q);
        ovf_d = 1'b1;
        if (!cfg_i.cap) extf_d = ~extf_d;  // silent toggle, no pin event
      end else begin
        cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end
    if (edge_cp) begin
      rld_d  = cnt_q;
      extf_d = 1'b1;
      evt_d  = 1'b1;
    end
    if (wr_cnt_i) cnt_d = wdata_i;
    if (wr_rld_i) rld_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      extf_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      ovf_q  <= ovf_d;
      extf_q <= extf_d;
      evt_q  <= evt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign ovf_o  = ovf_q;
  assign extf_o = extf_q;
  assign evt_o  = evt_q;

  assert_hold_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.run && !fall_i && !wr_cnt_i) |=> $stable(cnt_q));

  assert_up_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && up && !cfg_i.cap && cnt_q == rld_q && !fall_i && !wr_cnt_i && !wr_ctrl_i)
    |=> (cnt_q == '0 && ovf_q));

  assert_down_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !up && !cfg_i.cap && cnt_q == '0 && !fall_i && !wr_en_any())
    |=> (cnt_q == $past(rld_q)));

  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.cap && cfg_i.ext_en && fall_i && !wr_rld_i) |=> (rld_q == $past(cnt_q)));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !wr_ctrl_i) |=> ovf_q);

  function automatic logic wr_en_any();
    return wr_ctrl_i || wr_cnt_i || wr_rld_i;
  endfunction
endmodule

// File: rtl/tmr_cap_reload.sv
module tmr_cap_reload
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             ext_pin_i,
  output logic             tmr_o,
  output logic             irq_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cmp_q, cnt, rld;
  logic             wr_ctrl, wr_cnt, wr_rld, wr_cmp;
  logic             tick, level, fall, ovf, extf, evt;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_cnt  = wr_en_i && (addr_i == A_CNT);
  assign wr_rld  = wr_en_i && (addr_i == A_RLD);
  assign wr_cmp  = wr_en_i && (addr_i == A_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_ctrl) cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
      if (wr_cmp)  cmp_q <= wdata_i;
    end
  end

  tmr_pin_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .level_o(level), .fall_o(fall)
  );

  tmr_prescale u_presc (
    .clk_i, .rst_ni, .run_i(cfg_q.run), .code_i(cfg_q.presc), .tick_o(tick)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni, .cfg_i(cfg_q), .tick_i(tick), .level_i(level), .fall_i(fall),
    .wr_ctrl_i(wr_ctrl), .wr_cnt_i(wr_cnt), .wr_rld_i(wr_rld), .wdata_i,
    .cnt_o(cnt), .rld_o(rld), .ovf_o(ovf), .extf_o(extf), .evt_o(evt)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {ovf, extf, {(CNT_W-2-CFG_W){1'b0}}, cfg_q};
      A_CNT:   rdata_o = cnt;
      A_RLD:   rdata_o = rld;
      default: rdata_o = cmp_q;
    endcase
  end

  assign tmr_o = cfg_q.out_en && (cnt < cmp_q);
  assign irq_o = cfg_q.irq_en && (ovf || evt);

  // R10: a pending overflow with interrupts enabled is always signalled
  assert_irq_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.irq_en && ovf) |-> irq_o);
endmodule

// File: tb/sim_tmr_cap_reload.sv
`timescale 1ns/1ps
module sim_tmr_cap_reload;
  logic        clk = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0, ext_pin_i = 1'b1;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic        tmr_o, irq_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [1:0] CTRL = 2'd0, CNT = 2'd1, RLD = 2'd2, CMP = 2'd3;
  localparam int RUN = 1, CAP = 2, XEN = 4, DIRC = 8, OEN = 16, IEN = 32;
  localparam int EXTF = 1 << 14, OVF = 1 << 15;

  always #5 clk = ~clk;

  tmr_cap_reload u0 (.clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
                     .ext_pin_i, .tmr_o, .irq_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input int d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = 16'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int div_of(input int code);
    return (code <= 5) ? (1 << (2 * code)) : 1;
  endfunction

  function automatic int exp_up(input int s, input int r, input int t);
    return (s + t) % (r + 1);
  endfunction

  function automatic int exp_dn(input int s, input int r, input int t);
    return (s + (r + 1) - (t % (r + 1))) % (r + 1);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed_1234));
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 tmr_o", tmr_o, 0);
    chk("R1 irq_o", irq_o, 0);

    // R3 prescaler codes
    for (int c = 0; c < 8; c++) begin
      int k;
      k = 2 * div_of(c) + 1;
      wr(CTRL, 0); wr(RLD, 16'hFFFF); wr(CNT, 0);
      wr(CTRL, (c << 6) | RUN);
      cyc(k);
      rd(CNT, v); chk($sformatf("R3 code %0d", c), v, k / div_of(c));
    end

    // R2 run gating and hold
    wr(CTRL, 0); wr(CNT, 0); wr(CTRL, RUN);
    cyc(5);
    wr(CTRL, 0);
    rd(CNT, v); chk("R2 running", v, 6);
    cyc(10);
    rd(CNT, v); chk("R2 hold", v, 6);

    // R4 up wrap in reload mode, R10 irq sources
    wr(RLD, 5); wr(CNT, 3); wr(CTRL, RUN | IEN);
    cyc(3);
    rd(CNT, v); chk("R4 wrap to 0", v, 0);
    rd(CTRL, v); chk("R4 flags", v & (OVF | EXTF), OVF | EXTF);
    chk("R10 irq on ovf", irq_o, 1);
    wr(CTRL, IEN | EXTF);
    rd(CTRL, v); chk("R10 ext flag kept", v & (OVF | EXTF), EXTF);
    chk("R10 toggle no irq", irq_o, 0);
    wr(CNT, 5); wr(CTRL, RUN | IEN | EXTF);
    cyc(1);
    rd(CTRL, v); chk("R4 toggle back", v & (OVF | EXTF), OVF);

    // R9 sticky flag, R10 masked
    wr(CTRL, OVF);
    cyc(10);
    rd(CTRL, v); chk("R9 ovf sticky", v & OVF, OVF);
    chk("R10 masked", irq_o, 0);
    wr(CTRL, 0);
    rd(CTRL, v); chk("R9 ovf cleared", v & OVF, 0);

    // R5 down count with reload
    ext_pin_i = 1'b0; cyc(4);
    wr(RLD, 4); wr(CNT, 1); wr(CTRL, RUN | DIRC);
    cyc(2);
    rd(CNT, v); chk("R5 down reload", v, 4);
    rd(CTRL, v); chk("R5 ovf", v & OVF, OVF);
    wr(CTRL, DIRC);              // last tick on this edge: 4 -> 3
    ext_pin_i = 1'b1; cyc(4);
    wr(CTRL, RUN | DIRC);
    cyc(1);
    wr(CTRL, DIRC);              // 3 -> 4 -> 0 (wrap at reload value)
    rd(CNT, v); chk("R5 pin high counts up", v, 0);

    // R6 capture mode full range and capture
    wr(CTRL, 0); wr(CNT, 16'hFFFE); wr(CTRL, RUN | CAP);
    cyc(2);
    rd(CNT, v); chk("R6 wrap at max", v, 0);
    rd(CTRL, v); chk("R6 flags", v & (OVF | EXTF), OVF);
    wr(CTRL, CAP | XEN | IEN);
    wr(CNT, 16'h1234);
    ext_pin_i = 1'b0; cyc(5);
    rd(RLD, v); chk("R6 captured", v, 16'h1234);
    rd(CTRL, v); chk("R6 ext flag", v & (OVF | EXTF), EXTF);
    chk("R10 irq on event", irq_o, 1);

    // R8 pin disabled
    wr(CTRL, CAP); ext_pin_i = 1'b1; cyc(4);
    wr(CNT, 55); ext_pin_i = 1'b0; cyc(5);
    rd(RLD, v); chk("R8 no capture", v, 16'h1234);
    rd(CNT, v); chk("R8 count kept", v, 55);
    rd(CTRL, v); chk("R8 no flag", v & EXTF, 0);

    // R7 edge-forced reload
    wr(CTRL, 0); ext_pin_i = 1'b1; cyc(4);
    wr(RLD, 100); wr(CNT, 77); wr(CTRL, XEN);
    ext_pin_i = 1'b0; cyc(2);
    rd(CNT, v); chk("R7 not before sync", v, 77);
    cyc(1);
    rd(CNT, v); chk("R7 up forced 0", v, 0);
    rd(CTRL, v); chk("R7 up flag", v & EXTF, EXTF);
    wr(CTRL, XEN | DIRC); ext_pin_i = 1'b1; cyc(4);
    wr(CNT, 77); ext_pin_i = 1'b0; cyc(5);
    rd(CNT, v); chk("R7 down forced reload", v, 100);
    rd(CTRL, v); chk("R7 down no flag", v & EXTF, 0);

    // R11 compare output
    wr(CTRL, OEN); wr(CMP, 10); wr(CNT, 5);
    chk("R11 below", tmr_o, 1);
    wr(CNT, 10); chk("R11 equal", tmr_o, 0);
    wr(CNT, 9);  chk("R11 just below", tmr_o, 1);
    wr(CTRL, 0); chk("R11 disabled", tmr_o, 0);

    // R4 R5 R3 random reload runs in both directions
    for (int i = 0; i < 24; i++) begin
      int r, s, c, k, t, e;
      bit dn, o;
      r  = $urandom_range(40, 2);
      s  = $urandom_range(r, 0);
      c  = $urandom_range(2, 0);
      k  = $urandom_range(80, 1);
      dn = 1'($urandom_range(1, 0));
      wr(CTRL, 0);
      ext_pin_i = ~dn; cyc(4);
      wr(RLD, r); wr(CNT, s);
      wr(CTRL, (c << 6) | DIRC | RUN);
      cyc(k);
      t = k / div_of(c);
      e = dn ? exp_dn(s, r, t) : exp_up(s, r, t);
      o = dn ? (t > s) : (s + t > r);
      rd(CNT, v); chk($sformatf("%s random count", dn ? "R5" : "R4"), v, e);
      rd(CTRL, v); chk($sformatf("%s random ovf", dn ? "R5" : "R4"), v[15], o);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule